// File: doc/BRIEF.md
# Serial ADC Readout Host Controller

This block is the host side of a serial link to an 8-bit successive-approximation converter that has an address-driven input multiplexer. A single start request on the system clock starts one transaction. The block lowers chip select and produces a serial clock from the system clock through a divider. It sends a start bit followed by four address bits that select the channel and the input mode. It then stops driving the data line, so one wire can carry the address out and the result back.

On that line the converter first returns one settling bit, which the block discards. The converter then returns the conversion result twice: first with the most significant bit first, then repeated with the least significant bit first. The final bit of the first stream also serves as the first bit of the second. The block records both streams and compares them. A match gives a one-cycle valid pulse with the result. A mismatch gives a one-cycle error pulse. Chip select then rises and is held high for one full serial clock period before another request can be accepted.

Top module: `adc_rd_host`

## Requirements
- R1: After reset, cs_no is high, sclk_o is low, sdio_oe_o, busy_o, valid_o and error_o are low, and result_o is zero.
- R2: half_period_i is sampled when a request is accepted. Its value sets the length of each high phase and each low phase of sclk_o, in system cycles, and a value of 0 counts as 1. sclk_o is held low while cs_no is high. The first rising edge of sclk_o comes one half period after cs_no falls.
- R3: On serial rising edges 1 to 5 the line carries these bits in order: 1 (start), single_i (1 = single-ended), chan_i[0], chan_i[2], chan_i[1]. sdio_o changes only while sclk_o is low.
- R4: sdio_oe_o is high from the fall of cs_no through rising edge 5. It goes low at the next falling edge and stays low until the next transaction.
- R5: The bit sampled on rising edge 6 is a settling bit and does not affect the result.
- R6: The bits sampled on rising edges 7 to 14 form result_o, with the most significant bit first. result_o is updated when chip select rises.
- R7: The bits sampled on rising edges 15 to 21 are result bits 1 to 7 in that order. If they equal the first stream, valid_o is high for exactly one system cycle.
- R8: If any bit of the second stream differs from the first, error_o pulses for one cycle instead of valid_o. valid_o and error_o are never high together.
- R9: A transaction has exactly 21 serial rising edges. cs_no rises, and the valid or error flag is raised, on the system edge where sclk_o falls after the 21st rising edge.
- R10: busy_o is high exactly while cs_no is low. A start request is ignored while busy and during the gap of two half periods after cs_no rises.
- R11: chan_i and single_i are sampled only when a request is accepted. Changes to them during a transaction have no effect on the address sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transaction request, sampled in idle |
| chan_i | input | 3 | Channel number |
| single_i | input | 1 | 1 = single-ended, 0 = differential pair |
| half_period_i | input | DIV_W | System cycles per serial clock phase |
| cs_no | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| sdio_o | output | 1 | Data driven onto the shared line |
| sdio_oe_o | output | 1 | Drive enable for sdio_o |
| sdio_i | input | 1 | Data sampled from the shared line |
| result_o | output | RES_W | Last conversion result |
| valid_o | output | 1 | One-cycle pulse, streams matched |
| error_o | output | 1 | One-cycle pulse, streams differed |
| busy_o | output | 1 | Transaction in progress |

## Verification
A wrong edge count or an off-by-one in the phase counter shows up within one serial period. It appears as a misplaced address bit on the line, a drive enable that stays on into the settling bit, or a chip select that rises before or after the 21st edge. A capture fault that shifts the stream by one position gives a wrong result_o or a spurious error pulse when that same transaction ends. These outputs are checked against codes whose most and least significant bits differ, and against a converter model that corrupts one bit of the second stream on request. An accepted request that should have been dropped shows up as an extra chip select fall, either during a transaction or in the gap after one.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} rd_state_e;
endpackage

// File: rtl/adc_rd_clkdiv.sv
module adc_rd_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == half_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int RES_W       = 8,
  parameter int EDGE_W      = 5,
  parameter int SETTLE_EDGE = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              smp_i,
  input  logic [EDGE_W-1:0] edge_i,
  input  logic              bit_i,
  output logic [RES_W-1:0]  msb_o,
  output logic              match_o
);
  localparam int MsbLast = SETTLE_EDGE + RES_W;

  logic [RES_W-1:0] msb_q, lsb_q;
  logic             in_msb;

  assign in_msb  = (edge_i > EDGE_W'(SETTLE_EDGE)) && (edge_i <= EDGE_W'(MsbLast));
  assign msb_o   = msb_q;
  assign match_o = (msb_q == lsb_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              msb_q <= '0;
    else if (clr_i)           msb_q <= '0;
    else if (smp_i && in_msb) msb_q <= {msb_q[RES_W-2:0], bit_i};
  end

  // the last MSB-first bit is also bit 0 of the replay
  for (genvar k = 0; k < RES_W; k++) begin : g_lsb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      lsb_q[k] <= 1'b0;
      else if (clr_i)   lsb_q[k] <= 1'b0;
      else if (smp_i && edge_i == EDGE_W'(MsbLast + k)) lsb_q[k] <= bit_i;
    end
  end
endmodule

// File: rtl/adc_rd_host.sv
module adc_rd_host
  import adc_rd_pkg::*;
#(
  parameter int RES_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       chan_i,
  input  logic             single_i,
  input  logic [DIV_W-1:0] half_period_i,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             sdio_o,
  output logic             sdio_oe_o,
  input  logic             sdio_i,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o,
  output logic             error_o,
  output logic             busy_o
);
  localparam int AddrBits   = 5;                 // start + 4 address bits
  localparam int SettleEdge = AddrBits + 1;
  localparam int LastEdge   = SettleEdge + 2 * RES_W - 1;
  localparam int EdgeW      = $clog2(LastEdge + 1);

  rd_state_e         state_q;
  logic [EdgeW-1:0]  edge_q;
  logic [AddrBits-1:0] addr_q;
  logic [DIV_W-1:0]  hp_q;
  logic              sclk_q, cs_n_q, sdo_q, oe_q, valid_q, err_q;
  logic [RES_W-1:0]  res_q;
  logic              tick, smp, accept, match;
  logic [RES_W-1:0]  msb_word;

  assign accept = (state_q == ST_IDLE) && start_i;
  assign smp    = (state_q == ST_RUN) && tick && !sclk_q;

  adc_rd_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (state_q != ST_IDLE),
    .half_i(hp_q),
    .tick_o(tick)
  );

  adc_rd_capture #(.RES_W(RES_W), .EDGE_W(EdgeW), .SETTLE_EDGE(SettleEdge)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .smp_i  (smp),
    .edge_i (edge_q + EdgeW'(1)),
    .bit_i  (sdio_i),
    .msb_o  (msb_word),
    .match_o(match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      addr_q  <= '0;
      hp_q    <= DIV_W'(1);
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          addr_q  <= {chan_i[1], chan_i[2], chan_i[0], single_i, 1'b1};
          hp_q    <= (half_period_i == '0) ? DIV_W'(1) : half_period_i;
          cs_n_q  <= 1'b0;
          sdo_q   <= 1'b1;
          oe_q    <= 1'b1;
          edge_q  <= '0;
          sclk_q  <= 1'b0;
          state_q <= ST_RUN;
        end
        ST_RUN: if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            edge_q <= edge_q + EdgeW'(1);
          end else begin
            sclk_q <= 1'b0;
            if (edge_q == EdgeW'(LastEdge)) begin
              cs_n_q  <= 1'b1;
              res_q   <= msb_word;
              valid_q <= match;
              err_q   <= !match;
              edge_q  <= '0;
              state_q <= ST_GAP;
            end else if (edge_q < EdgeW'(AddrBits)) begin
              sdo_q  <= addr_q[1];
              addr_q <= {1'b0, addr_q[AddrBits-1:1]};
            end else if (edge_q == EdgeW'(AddrBits)) begin
              oe_q  <= 1'b0;
              sdo_q <= 1'b0;
            end
          end
        end
        ST_GAP: if (tick) begin
          if (edge_q == EdgeW'(1)) state_q <= ST_IDLE;
          else                     edge_q  <= edge_q + EdgeW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no     = cs_n_q;
  assign sclk_o    = sclk_q;
  assign sdio_o    = sdo_q;
  assign sdio_oe_o = oe_q;
  assign result_o  = res_q;
  assign valid_o   = valid_q;
  assign error_o   = err_q;
  assign busy_o    = (state_q == ST_RUN);
endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_no,
  input logic             sclk_o,
  input logic             sdio_o,
  input logic             sdio_oe_o,
  input logic             valid_o,
  input logic             error_o,
  input logic             busy_o,
  input logic [DIV_W-1:0] hp_i
);
  logic [DIV_W:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_cnt <= '0;
    else if (sclk_o) hi_cnt <= hi_cnt + 1'b1;
    else             hi_cnt <= '0;
  end

  AST_SCLK_REST_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o); // R2
  AST_HIGH_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> (hi_cnt < {1'b0, hp_i})); // R2
  AST_DI_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdio_o)); // R3
  AST_NO_DRIVE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sdio_oe_o); // R4
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R7
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({valid_o, error_o})); // R8
  AST_FLAG_AT_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || error_o) |-> $rose(cs_no)); // R9
  AST_BUSY_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o != cs_no); // R10
endmodule

bind adc_rd_host adc_rd_chk #(.DIV_W(DIV_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_no    (cs_no),
  .sclk_o   (sclk_o),
  .sdio_o   (sdio_o),
  .sdio_oe_o(sdio_oe_o),
  .valid_o  (valid_o),
  .error_o  (error_o),
  .busy_o   (busy_o),
  .hp_i     (hp_q)
);

// File: tb/adc_rd_host_tb_top.sv
module adc_rd_host_tb_top;
  localparam int Tclk = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] chan = '0;
  logic       single = 1'b0;
  logic [7:0] half = 8'd2;
  logic       cs_n, sclk, sdo, oe, valid, err, busy;
  logic [7:0] result;
  logic       line;
  logic       adc_do = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #(Tclk/2) clk = ~clk;

  assign line = oe ? sdo : adc_do;

  adc_rd_host dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_i(chan), .single_i(single),
    .half_period_i(half), .cs_no(cs_n), .sclk_o(sclk), .sdio_o(sdo), .sdio_oe_o(oe),
    .sdio_i(line), .result_o(result), .valid_o(valid), .error_o(err), .busy_o(busy)
  );

  // converter model
  logic [7:0] code = '0;
  logic       corrupt = 1'b0;
  int         nrise = 0;
  int         n_cs_fall = 0;
  logic [4:0] addr_seen = '0;
  logic       oe_bad = 1'b0;
  time        t_cs, t_r1, t_r2, t_f1;

  always @(negedge cs_n) begin
    nrise = 0; addr_seen = '0; adc_do = 1'b0; oe_bad = 1'b0;
    t_cs = $time; n_cs_fall++;
  end

  always @(posedge sclk) if (!cs_n) begin
    nrise++;
    if (nrise <= 5) begin
      addr_seen[nrise-1] = line;
      if (!oe) oe_bad = 1'b1;
    end else if (oe) oe_bad = 1'b1;
    if (nrise == 1) t_r1 = $time;
    if (nrise == 2) t_r2 = $time;
  end

  always @(negedge sclk) if (!cs_n) begin
    if (nrise == 1) t_f1 = $time;
    if (nrise == 5) adc_do = 1'b1;  // settling bit driven high: must be discarded
    else if (nrise >= 6 && nrise <= 13) adc_do = code[13-nrise];
    else if (nrise >= 14 && nrise <= 20) adc_do = code[nrise-13] ^ (corrupt && nrise == 16);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(cs_n === 1'b1, "R1", "cs_no", cs_n, 1);
    chk(sclk === 1'b0, "R1", "sclk_o", sclk, 0);
    chk(oe === 1'b0, "R1", "sdio_oe_o", oe, 0);
    chk(busy === 1'b0, "R1", "busy_o", busy, 0);
    chk(valid === 1'b0 && err === 1'b0, "R1", "flags", {valid, err}, 0);
    chk(result === 8'h00, "R1", "result_o", result, 0);
  endtask

  // poke: mid-run start + input change (R10, R11); gap_poke: start in gap (R10)
  task automatic t_txn(input logic [2:0] ch, input logic sg, input int hp,
                       input logic [7:0] c, input bit bad, input bit poke, input bit gap_poke);
    int eff = (hp == 0) ? 1 : hp;
    int falls0;
    bit seen = 0;
    logic [4:0] exp_addr = {ch[1], ch[2], ch[0], sg, 1'b1};
    code = c; corrupt = bad;
    @(negedge clk);
    chan = ch; single = sg; half = 8'(hp); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    falls0 = n_cs_fall;
    chk(busy === 1'b1 && cs_n === 1'b0, "R10", "busy at cs fall", {busy, cs_n}, 2'b10);
    if (poke) begin
      repeat (12 * eff) @(negedge clk);
      chan = ~ch; single = ~sg; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 20000; i++) begin
      if (valid || err) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen, "R9", "flag seen", seen, 1);
    chk(cs_n === 1'b1 && busy === 1'b0, "R9", "cs high with flag", {cs_n, busy}, 2'b10);
    chk(nrise == 21, "R9", "rising edges", nrise, 21);
    chk(addr_seen == exp_addr, "R3", "address bits", addr_seen, exp_addr);
    chk(!oe_bad, "R4", "drive enable window", oe_bad, 0);
    chk(result == c, "R6", "result_o (R5 settle bit high)", result, c);
    if (bad) chk(err === 1'b1 && valid === 1'b0, "R8", "mismatch flags", {valid, err}, 2'b01);
    else     chk(valid === 1'b1 && err === 1'b0, "R7", "match flags", {valid, err}, 2'b10);
    chk(longint'(t_r1 - t_cs) == longint'(eff * Tclk), "R2", "cs setup", t_r1 - t_cs, eff * Tclk);
    chk(longint'(t_f1 - t_r1) == longint'(eff * Tclk), "R2", "high phase", t_f1 - t_r1, eff * Tclk);
    chk(longint'(t_r2 - t_r1) == longint'(2 * eff * Tclk), "R2", "period", t_r2 - t_r1, 2 * eff * Tclk);
    if (poke) chk(n_cs_fall == falls0, "R11", "mid-run start ignored", n_cs_fall, falls0);
    @(negedge clk);
    chk(valid === 1'b0 && err === 1'b0, "R7", "flag one cycle", {valid, err}, 0);
    if (gap_poke) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2 * eff + 3) @(negedge clk);
      chk(cs_n === 1'b1 && n_cs_fall == falls0, "R10", "start in gap ignored", n_cs_fall, falls0);
    end else begin
      repeat (2 * eff + 2) @(negedge clk);
    end
  endtask

  initial begin
    #(longint'(200000) * Tclk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_txn(3'd0, 1'b1, 2,   8'hA5, 1'b0, 1'b0, 1'b0);
    t_txn(3'd5, 1'b0, 3,   8'h00, 1'b0, 1'b0, 1'b0);
    t_txn(3'd6, 1'b1, 0,   8'hFF, 1'b0, 1'b0, 1'b0);
    t_txn(3'd3, 1'b1, 100, 8'h81, 1'b0, 1'b0, 1'b0);
    t_txn(3'd2, 1'b0, 2,   8'h3C, 1'b1, 1'b0, 1'b0);
    t_txn(3'd7, 1'b1, 4,   8'h5A, 1'b0, 1'b1, 1'b0);
    t_txn(3'd1, 1'b0, 2,   8'hC3, 1'b0, 1'b0, 1'b1);
    t_txn(3'd4, 1'b1, 2,   8'h01, 1'b0, 1'b0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule